// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the status byte of an asynchronous serial port. The byte has eight flags: transmit-data-empty, receive-data-full, overrun, framing error, parity error, transmit-end, received multiprocessor bit and multiprocessor bit to send. Single-cycle event strobes from the transmit and receive datapaths set the flags. When a character completes, the block also works out the framing and parity errors from the raw character, its parity bit and its stop bit.

A CPU bus reads the byte at one fixed address. Software clears an event flag in two steps. It first reads the byte while that flag is 1, and then writes a 0 to that bit position. Accesses to the transmit and receive data registers arrive as strobes and also change the flags.

Top module: `uart_stat_reg`

## Requirements
- R1: After reset the status byte is 0x84. Bit order from MSB to LSB is: tx-empty(7), rx-full(6), overrun(5), framing(4), parity(3), tx-end(2), rx-mp-bit(1), tx-mp-bit(0).
- R2: A bus read with `bus_sel` and `bus_rd` at the address `REG_OFFSET` (default 0xAC) returns the status byte combinationally on `bus_rdata`. A read at any other address returns 0x00, and a write at any other address leaves every flag unchanged.
- R3: A write of 0 to bit 7..3 clears that flag only if a read of the register saw the flag at 1 after the previous write to the register. Any write to the register consumes all pending read qualifiers.
- R4: A write of 1 to bit 7..3 or to bit 1 never changes the flag. Bit 1 is read-only. Bit 0 takes `bus_wdata[0]` on every write to the register.
- R5: `tx_load` or `tx_en_clr` sets tx-empty. `tx_data_wr` or an accepted software clear of bit 7 clears tx-empty.
- R6: tx-end sets on `tx_en_clr`, or on `tx_last_bit` while tx-empty is 1. It clears whenever tx-empty actually goes from set to clear.
- R7: On `rx_done`, rx-full sets when the character has no framing or parity error, rx-full is 0, and neither overrun nor framing is pending. In that case bit 1 takes `rx_mpb`. `rx_data_rd` clears rx-full.
- R8: `rx_done` while rx-full is 1 sets overrun.
- R9: `rx_done` with `rx_stop_bit` = 0 sets the framing flag.
- R10: With `par_en` = 1, `rx_done` sets the parity flag when the XOR of `rx_data` and `rx_par_bit` differs from `par_odd` (1 = odd parity).
- R11: In any cycle, a hardware set event takes priority over a software or hardware clear of the same flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus cycle select |
| bus_rd | input | 1 | Bus read |
| bus_wr | input | 1 | Bus write |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| tx_data_wr | input | 1 | Strobe: transmit data register written |
| tx_load | input | 1 | Strobe: transmit data moved to shift register |
| tx_last_bit | input | 1 | Strobe: last bit of a character sent |
| tx_en_clr | input | 1 | Strobe: transmit enable cleared |
| rx_done | input | 1 | Strobe: character reception complete |
| rx_data | input | DATA_W | Received character |
| rx_par_bit | input | 1 | Received parity bit |
| rx_stop_bit | input | 1 | Sampled stop bit |
| rx_mpb | input | 1 | Received multiprocessor bit |
| par_en | input | 1 | Parity checking enabled |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rx_data_rd | input | 1 | Strobe: receive data register read |
| flags_o | output | 8 | Current status byte |

## Verification
The two-step clear is tried in four ways. The first is a zero-write with no read before it, which shows that a qualifier is needed. The second is a read followed by a zero-write, which shows the clear works. The third is a read, then a harmless write, then a zero-write, which shows that any write consumes the qualifier. The fourth is a read at a foreign address, which shows that address decode gates arming. Receive characters are applied as a clean frame, a frame with rx-full already set, a frame after rx-full has been drained while overrun is still pending, a bad stop bit, and a parity mismatch under odd parity. Together these separate normal loading, overrun, blocking, framing and parity. A software clear that coincides with a load strobe shows that the set event takes priority.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
    localparam int B_TDE  = 7;
    localparam int B_RDF  = 6;
    localparam int B_OVR  = 5;
    localparam int B_FRM  = 4;
    localparam int B_PAR  = 3;
    localparam int B_TEND = 2;
    localparam int B_MPR  = 1;
    localparam int B_MPT  = 0;
    localparam logic [7:0] RST_VAL  = 8'h84;
    localparam logic [7:0] ARM_MASK = 8'hF8;

    typedef struct packed {
        logic [7:0] flags;
        logic [7:0] armed;
    } stat_state_t;
endpackage

// File: rtl/usr_bus_dec.sv
module usr_bus_dec #(
    parameter int          ADDR_W = 8,
    parameter logic [ADDR_W-1:0] OFFSET = 'hAC
) (
    input  logic              sel,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_hit,
    output logic              wr_hit
);
    logic match;
    always_comb begin
        match  = sel && (addr == OFFSET);
        rd_hit = match && rd;
        wr_hit = match && wr;
    end
endmodule

// File: rtl/usr_rx_check.sv
module usr_rx_check #(
    parameter int DATA_W = 8
) (
    input  logic              done,
    input  logic [DATA_W-1:0] data,
    input  logic              par_bit,
    input  logic              stop_bit,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              frm_err,
    output logic              par_err
);
    logic ones_odd;
    always_comb begin
        ones_odd = ^{data, par_bit};
        frm_err  = done && !stop_bit;
        par_err  = done && par_en && (ones_odd != par_odd);
    end
endmodule

// File: rtl/uart_stat_reg.sv
module uart_stat_reg
    import uart_stat_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'hAC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              tx_data_wr,
    input  logic              tx_load,
    input  logic              tx_last_bit,
    input  logic              tx_en_clr,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par_bit,
    input  logic              rx_stop_bit,
    input  logic              rx_mpb,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rx_data_rd,
    output logic [7:0]        flags_o
);
    stat_state_t st_d, st_q;
    logic rd_hit, wr_hit, frm_err, par_err;
    logic [7:0] sw_clr;
    logic tde_set, tde_clr, tend_set, rdf_set, ovr_set, rx_blocked;

    usr_bus_dec #(.ADDR_W(ADDR_W), .OFFSET(REG_OFFSET)) dec_i (
        .sel(bus_sel), .rd(bus_rd), .wr(bus_wr), .addr(bus_addr),
        .rd_hit(rd_hit), .wr_hit(wr_hit)
    );

    usr_rx_check #(.DATA_W(DATA_W)) chk_i (
        .done(rx_done), .data(rx_data), .par_bit(rx_par_bit),
        .stop_bit(rx_stop_bit), .par_en(par_en), .par_odd(par_odd),
        .frm_err(frm_err), .par_err(par_err)
    );

    always_comb begin
        st_d       = st_q;
        sw_clr     = wr_hit ? (st_q.armed & ~bus_wdata) : 8'h00;
        tde_set    = tx_en_clr || tx_load;
        tde_clr    = sw_clr[B_TDE] || tx_data_wr;
        tend_set   = tx_en_clr || (tx_last_bit && st_q.flags[B_TDE]);
        rx_blocked = st_q.flags[B_OVR] || st_q.flags[B_FRM];
        rdf_set    = rx_done && !frm_err && !par_err
                     && !st_q.flags[B_RDF] && !rx_blocked;
        ovr_set    = rx_done && st_q.flags[B_RDF];

        if (rd_hit)
            st_d.armed = st_q.armed | (st_q.flags & ARM_MASK);
        if (wr_hit) begin
            st_d.armed        = 8'h00;
            st_d.flags[B_MPT] = bus_wdata[B_MPT];
        end

        if (tde_set)      st_d.flags[B_TDE] = 1'b1;
        else if (tde_clr) st_d.flags[B_TDE] = 1'b0;

        if (tend_set)
            st_d.flags[B_TEND] = 1'b1;
        else if (tde_clr && !tde_set && st_q.flags[B_TDE])
            st_d.flags[B_TEND] = 1'b0;

        if (rdf_set) begin
            st_d.flags[B_RDF] = 1'b1;
            st_d.flags[B_MPR] = rx_mpb;
        end else if (sw_clr[B_RDF] || rx_data_rd) begin
            st_d.flags[B_RDF] = 1'b0;
        end

        if (ovr_set)            st_d.flags[B_OVR] = 1'b1;
        else if (sw_clr[B_OVR]) st_d.flags[B_OVR] = 1'b0;

        if (frm_err)            st_d.flags[B_FRM] = 1'b1;
        else if (sw_clr[B_FRM]) st_d.flags[B_FRM] = 1'b0;

        if (par_err)            st_d.flags[B_PAR] = 1'b1;
        else if (sw_clr[B_PAR]) st_d.flags[B_PAR] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flags <= RST_VAL;
            st_q.armed <= 8'h00;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        flags_o   = st_q.flags;
        bus_rdata = rd_hit ? st_q.flags : 8'h00;
    end
endmodule

// File: rtl/uart_stat_reg_sva.sv
module uart_stat_reg_sva #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'hAC
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              tx_load,
    input logic              tx_data_wr,
    input logic              rx_done,
    input logic              rx_data_rd,
    input logic [7:0]        flags_o
);
    logic wr_here;
    assign wr_here = bus_sel && bus_wr && (bus_addr == REG_OFFSET);

    a_r5_load_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> flags_o[7]);

    a_r8_overrun_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && flags_o[6]) |=> flags_o[5]);

    a_r4_one_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_here && bus_wdata[7] && flags_o[7] && !tx_data_wr) |=> flags_o[7]);

    a_r7_rdread_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_data_rd && !rx_done) |=> !flags_o[6]);

    a_r4_mpr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |=> $stable(flags_o[1]));

    a_r4_mpt_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_here |=> (flags_o[0] == $past(bus_wdata[0])));
endmodule

bind uart_stat_reg uart_stat_reg_sva #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) sva_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tx_load(tx_load),
    .tx_data_wr(tx_data_wr), .rx_done(rx_done), .rx_data_rd(rx_data_rd),
    .flags_o(flags_o)
);

// File: tb/uart_stat_reg_tb.sv
module uart_stat_reg_tb_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_sel = 0, bus_rd = 0, bus_wr = 0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, bus_rdata;
    logic tx_data_wr = 0, tx_load = 0, tx_last_bit = 0, tx_en_clr = 0;
    logic rx_done = 0, rx_par_bit = 0, rx_stop_bit = 1, rx_mpb = 0;
    logic par_en = 1, par_odd = 0, rx_data_rd = 0;
    logic [7:0] rx_data = 8'h00, flags_o;
    int n_chk = 0, n_bad = 0;
    localparam logic [7:0] REG = 8'hAC;

    always #4 clk = ~clk;

    uart_stat_reg dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tx_data_wr(tx_data_wr), .tx_load(tx_load),
        .tx_last_bit(tx_last_bit), .tx_en_clr(tx_en_clr), .rx_done(rx_done),
        .rx_data(rx_data), .rx_par_bit(rx_par_bit), .rx_stop_bit(rx_stop_bit),
        .rx_mpb(rx_mpb), .par_en(par_en), .par_odd(par_odd),
        .rx_data_rd(rx_data_rd), .flags_o(flags_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rx_frame(input logic [7:0] d, input logic p, input logic s, input logic m);
        @(negedge clk);
        rx_data = d; rx_par_bit = p; rx_stop_bit = s; rx_mpb = m; rx_done = 1;
        @(negedge clk);
        rx_done = 0; rx_stop_bit = 1;
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            0: tx_load = 1;
            1: tx_last_bit = 1;
            2: tx_data_wr = 1;
            3: tx_en_clr = 1;
            default: rx_data_rd = 1;
        endcase
        @(negedge clk);
        tx_load = 0; tx_last_bit = 0; tx_data_wr = 0; tx_en_clr = 0; rx_data_rd = 0;
    endtask

    task automatic t_reset;
        check("R1 reset value", flags_o, 8'h84);
        check("R2 idle rdata", bus_rdata, 8'h00);
    endtask

    task automatic t_two_step_clear;
        logic [7:0] v;
        wr(REG, 8'h00);
        check("R3 clear without read", flags_o, 8'h84);
        rd(REG, v);
        check("R2 read value", v, 8'h84);
        wr(REG, 8'h00);
        check("R3 R6 read then zero clears", flags_o, 8'h00);
    endtask

    task automatic t_tx_flags;
        strobe(1);
        check("R6 last bit with empty 0", flags_o, 8'h00);
        strobe(0);
        check("R5 load sets empty", flags_o, 8'h80);
        strobe(1);
        check("R6 last bit sets end", flags_o, 8'h84);
        strobe(2);
        check("R5 R6 data write clears", flags_o, 8'h00);
        strobe(3);
        check("R5 R6 enable clear sets", flags_o, 8'h84);
    endtask

    task automatic t_rx_chain;
        logic [7:0] v;
        rx_frame(8'h35, 1'b0, 1'b1, 1'b1);
        check("R7 clean frame", flags_o, 8'hC6);
        rx_frame(8'h35, 1'b0, 1'b1, 1'b0);
        check("R8 overrun", flags_o, 8'hE6);
        strobe(4);
        check("R7 data read clears full", flags_o, 8'hA6);
        rx_frame(8'h35, 1'b0, 1'b1, 1'b0);
        check("R7 blocked by overrun", flags_o, 8'hA6);
        rd(REG, v);
        wr(REG, 8'hDD);
        check("R4 R3 overrun cleared, ones kept", flags_o, 8'h87);
    endtask

    task automatic t_errors;
        logic [7:0] v;
        rx_frame(8'h35, 1'b0, 1'b0, 1'b0);
        check("R9 framing", flags_o, 8'h97);
        par_odd = 1;
        rx_frame(8'h35, 1'b0, 1'b1, 1'b0);
        check("R10 parity mismatch", flags_o, 8'h9F);
        rd(REG, v);
        wr(REG, 8'hFF);
        wr(REG, 8'hE7);
        check("R3 qualifier consumed", flags_o, 8'h9F);
        rd(REG, v);
        wr(REG, 8'hE7);
        check("R3 errors cleared", flags_o, 8'h87);
        rx_frame(8'h34, 1'b0, 1'b1, 1'b0);
        check("R10 odd parity matched, R7 loads", flags_o, 8'hC5);
        par_odd = 0;
        strobe(4);
    endtask

    task automatic t_priority_and_decode;
        logic [7:0] v;
        rd(REG, v);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = REG; bus_wdata = 8'h7D; tx_load = 1;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; tx_load = 0;
        check("R11 set beats clear", flags_o, 8'h85);
        rd(8'hAD, v);
        check("R2 foreign read zero", v, 8'h00);
        wr(REG, 8'h79);
        check("R2 foreign read does not arm", flags_o, 8'h85);
        rd(REG, v);
        wr(8'hAD, 8'h00);
        check("R2 foreign write ignored", flags_o, 8'h85);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_two_step_clear();
        t_tx_flags();
        t_rx_chain();
        t_errors();
        t_priority_and_decode();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule